// File: doc/BRIEF.md
# Dual-Edge Masked Interrupt Controller

This block watches 24 status lines and turns selected transitions on them into a level interrupt request. Twenty lines come straight from external signals. Four are derived inside the block: all external signals high, all test-trip signals high, both logic-block health flags high, and the heartbeat-in health flag. Every line passes through a two-flop synchroniser. Rising and falling edges are detected separately, and each has its own mask bit.

An enabled edge sets a sticky bit in a transition image. Reading an image word clears that word. While interrupts are enabled and any image bit is set, the request output is high. The interrupt level and vector are packed into one settings word and driven onto outputs for an external arbiter, which handles the acknowledge.

Software reaches all of this through a 16-bit word-addressed register port. Word addresses 0 to 2 hold the masks for lines 0–7, 8–15 and 16–23. Addresses 3 to 5 hold the transition images for the same line groups. Address 6 holds the settings word. Any other address reads as zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: An input change that is stable before rising clock edge k appears in the transition image after edge k+2, and not earlier.
- R2: Line n maps to mask and image word n/8. Within that word, bit 2·(n mod 8)+1 is the rising edge and bit 2·(n mod 8) is the falling edge.
- R3: An image bit is set only when its mask bit is 1 in the cycle the edge is captured.
- R4: A set image bit stays set until its word is read, even if the mask bit is cleared afterwards.
- R5: A read strobe on image word 3, 4 or 5 returns the current contents of that word and clears it on the same clock. The other image words are left intact.
- R6: An enabled edge captured on the same clock as the clearing read of its word is kept. The read returns the old contents.
- R7: Line 20 is the AND of all external signals. Line 21 is the AND of all trip-test inputs. Line 22 is lb1_ok AND lb2_ok. Line 23 is hb_ok.
- R8: irq_req is 1 exactly when settings bit 11 (enable) is 1 and at least one image bit is set. With enable at 0, edges are still captured.
- R9: The settings word at address 6 stores bit 11 (enable), bits 10:8 (irq_level) and bits 7:0 (irq_vector). Written bits 15:12 are discarded and read back as 0. irq_level and irq_vector follow the stored fields.
- R10: The mask words at addresses 0–2 read back as written. After they are cleared to 0 and set back to all ones, new edges raise the request again.
- R11: After reset, every mask, image and settings bit is 0 and irq_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | EXT_W (20) | External signals, lines 0 to EXT_W-1 |
| trip_in | input | TRIP_W (21) | Trip-test inputs, AND-reduced onto line 21 |
| lb1_ok | input | 1 | Logic block 1 health |
| lb2_ok | input | 1 | Logic block 2 health |
| hb_ok | input | 1 | Heartbeat-in health |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rd | input | 1 | Read strobe; clears the addressed image word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt level |
| irq_vector | output | 8 | Interrupt vector |

## Verification
The bench targets the clear-versus-capture collision. A design that lets the clear win would drop an edge landing on the read clock, and the request would never rise for it. The bench also checks that each read clears only the word it addresses, so a design that clears every image word on any read would lose pending edges in the other words. Capture timing is checked to the exact clock: an extra or missing synchroniser stage shows up as a one-cycle shift in irq_req.

Further cases cover a mask bit cleared after capture, which a non-sticky image would forget, and the AND conditions on the derived lines. A design that raises line 22 on one health flag alone would record a spurious edge. With enable low, the request must stay off while edges keep being recorded, so turning enable back on must raise the request at once.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int EXT_W  = 20,
  parameter int TRIP_W = 21,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_W-1:0]  sig_in,
  input  logic [TRIP_W-1:0] trip_in,
  input  logic              lb1_ok,
  input  logic              lb2_ok,
  input  logic              hb_ok,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq_req,
  output logic [2:0]        irq_level,
  output logic [7:0]        irq_vector
);
  localparam int N_LINES  = EXT_W + 4;
  localparam int NW       = (N_LINES + 7) / 8;
  localparam int VW       = NW * 16;
  localparam int SET_ADDR = 2 * NW;

  logic [N_LINES-1:0] raw, s1, s2, s3;
  logic [VW-1:0]      mask_q, img_q, edges, clr;
  logic [11:0]        set_q;
  logic               unused_hi;

  assign raw       = {hb_ok, lb1_ok & lb2_ok, &trip_in, &sig_in, sig_in};
  assign unused_hi = ^reg_wdata[15:12];

  always_comb begin
    edges = '0;
    for (int i = 0; i < N_LINES; i++) begin
      edges[2*i+1] = s2[i] & ~s3[i];
      edges[2*i]   = ~s2[i] & s3[i];
    end
  end

  always_comb begin
    for (int w = 0; w < NW; w++)
      clr[16*w +: 16] = {16{reg_rd && reg_addr == ADDR_W'(NW + w)}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      mask_q <= '0;
      img_q  <= '0;
      set_q  <= '0;
    end else begin
      s1    <= raw;
      s2    <= s1;
      s3    <= s2;
      img_q <= (img_q & ~clr) | (edges & mask_q);
      for (int w = 0; w < NW; w++)
        if (reg_wr && reg_addr == ADDR_W'(w))
          mask_q[16*w +: 16] <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_W'(SET_ADDR))
        set_q <= reg_wdata[11:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (reg_addr == ADDR_W'(w))      reg_rdata = mask_q[16*w +: 16];
      if (reg_addr == ADDR_W'(NW + w)) reg_rdata = img_q[16*w +: 16];
    end
    if (reg_addr == ADDR_W'(SET_ADDR)) reg_rdata = {4'h0, set_q};
  end

  assign irq_req    = set_q[11] & (|img_q);
  assign irq_level  = set_q[10:8];
  assign irq_vector = set_q[7:0];
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int EXT_W  = 20,
  parameter int ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_rd,
  input logic                         reg_wr,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic                         irq_req,
  input logic [2:0]                   irq_level,
  input logic [7:0]                   irq_vector,
  input logic [((EXT_W+11)/8)*16-1:0] mask_q,
  input logic [((EXT_W+11)/8)*16-1:0] img_q,
  input logic                         en
);
  localparam int NW       = (EXT_W + 11) / 8;
  localparam int SET_ADDR = 2 * NW;

  logic img_read;
  assign img_read = reg_rd && (reg_addr >= ADDR_W'(NW)) && (reg_addr < ADDR_W'(2 * NW));

  a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((img_q & ~$past(img_q) & ~$past(mask_q)) == '0));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !img_read |=> ((img_q & $past(img_q)) == $past(img_q)));

  a_r5_word_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(NW)) |=> ((img_q[15:0] & ~$past(mask_q[15:0])) == 16'h0));

  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (img_q == '0) |-> !irq_req);

  a_r9_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(SET_ADDR)) |=> ($stable(irq_level) && $stable(irq_vector)));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.EXT_W(EXT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
  .mask_q(mask_q), .img_q(img_q), .en(set_q[11])
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] sig = '0;
  logic [20:0] trip = '0;
  logic        lb1 = 1'b0, lb2 = 1'b0, hb = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .trip_in(trip),
    .lb1_ok(lb1), .lb2_ok(lb2), .hb_ok(hb),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  // Behavioural reference model
  logic [47:0] m_mask, m_img;
  logic [11:0] m_set;
  logic [23:0] hist[$];

  function automatic logic [23:0] line_values();
    return {hb, lb1 & lb2, &trip, &sig, sig};
  endfunction

  always @(posedge clk) begin
    logic [23:0] newer, older;
    if (!rst_n) begin
      m_mask = '0;
      m_img  = '0;
      m_set  = '0;
      hist   = {24'h0, 24'h0, 24'h0};
    end else begin
      newer = hist[1];
      older = hist[2];
      if (reg_rd && reg_addr >= 3 && reg_addr <= 5)
        m_img[16*(reg_addr-3) +: 16] = 16'h0;
      for (int n = 0; n < 24; n++) begin
        if (newer[n] && !older[n] && m_mask[2*n+1]) m_img[2*n+1] = 1'b1;
        if (!newer[n] && older[n] && m_mask[2*n])   m_img[2*n]   = 1'b1;
      end
      if (reg_wr && reg_addr <= 2) m_mask[16*reg_addr +: 16] = reg_wdata;
      if (reg_wr && reg_addr == 6) m_set = reg_wdata[11:0];
      hist.push_front(line_values());
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] exp_rd;
    if (rst_n && !done) begin
      check("R8 irq_req vs model", {31'h0, irq_req}, {31'h0, m_set[11] && (|m_img)});
      check("R9 irq_level vs model", {29'h0, irq_level}, {29'h0, m_set[10:8]});
      check("R9 irq_vector vs model", {24'h0, irq_vector}, {24'h0, m_set[7:0]});
      case (reg_addr)
        3'd0, 3'd1, 3'd2: exp_rd = m_mask[16*reg_addr +: 16];
        3'd3, 3'd4, 3'd5: exp_rd = m_img[16*(reg_addr-3) +: 16];
        3'd6:             exp_rd = {4'h0, m_set};
        default:          exp_rd = 16'h0;
      endcase
      check("R2 reg_rdata vs model", {16'h0, reg_rdata}, {16'h0, exp_rd});
    end
  end

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); #1;
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    @(negedge clk); #1;
    reg_addr = 3'(a); reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    check("R11 irq_req after reset", {31'h0, irq_req}, 32'h0);
    rd(0, d); check("R11 mask0 after reset", {16'h0, d}, 32'h0);
    rd(3, d); check("R11 image0 after reset", {16'h0, d}, 32'h0);
    rd(6, d); check("R11 settings after reset", {16'h0, d}, 32'h0);

    // R9 settings packing, upper bits discarded
    wr(6, 16'hFAA5);
    rd(6, d); check("R9 settings readback", {16'h0, d}, 32'h0AA5);
    check("R9 level", {29'h0, irq_level}, 32'h2);
    check("R9 vector", {24'h0, irq_vector}, 32'hA5);

    for (int w = 0; w < 3; w++) wr(w, 16'hFFFF);
    rd(1, d); check("R10 mask1 readback", {16'h0, d}, 32'hFFFF);
    for (int w = 3; w < 6; w++) rd(w, d);

    // R1 capture timing
    @(negedge clk); #1 sig[5] = 1'b1;
    @(negedge clk); check("R1 no capture after 1 edge", {31'h0, irq_req}, 32'h0);
    @(negedge clk); check("R1 no capture after 2 edges", {31'h0, irq_req}, 32'h0);
    @(negedge clk); check("R1 capture after 3 edges", {31'h0, irq_req}, 32'h1);
    rd(3, d); check("R2 line5 rising bit 11", {16'h0, d}, 32'h0800);
    @(negedge clk); check("R8 request drops after clear", {31'h0, irq_req}, 32'h0);

    @(negedge clk); #1 sig[5] = 1'b0;
    idle(5);
    rd(3, d); check("R2 line5 falling bit 10", {16'h0, d}, 32'h0400);

    @(negedge clk); #1 sig[13] = 1'b1;
    idle(5);
    rd(3, d); check("R2 word0 untouched by line13", {16'h0, d}, 32'h0);
    rd(4, d); check("R2 line13 rising in word1", {16'h0, d}, 32'h0800);

    // R3 mask gating
    wr(0, 16'hFFFD);
    @(negedge clk); #1 sig[0] = 1'b1;
    idle(5);
    rd(3, d); check("R3 masked rising not captured", {16'h0, d}, 32'h0);
    @(negedge clk); #1 sig[0] = 1'b0;
    idle(5);
    rd(3, d); check("R3 enabled falling captured", {16'h0, d}, 32'h0001);

    // R4 sticky after mask clear
    @(negedge clk); #1 sig[1] = 1'b1;
    idle(5);
    wr(0, 16'h0000);
    idle(2);
    rd(3, d); check("R4 bit held after mask clear", {16'h0, d}, 32'h0008);
    wr(0, 16'hFFFF);

    // R5 per-word clear
    @(negedge clk); #1 sig[2] = 1'b1; sig[9] = 1'b1;
    idle(5);
    rd(3, d); check("R5 word0 contents", {16'h0, d}, 32'h0020);
    rd(4, d); check("R5 word1 survives word0 read", {16'h0, d}, 32'h0008);

    // R6 edge on the clearing read cycle
    @(negedge clk); #1 sig[3] = 1'b1;
    @(negedge clk);
    rd(3, d); check("R6 read returns old contents", {16'h0, d}, 32'h0);
    rd(3, d); check("R6 colliding edge kept", {16'h0, d}, 32'h0080);

    // R7 derived lines
    for (int w = 3; w < 6; w++) rd(w, d);
    @(negedge clk); #1 sig = '1;
    idle(5);
    rd(5, d); check("R7 all-signals line 20", {16'h0, d}, 32'h02AA);
    rd(3, d); rd(4, d);
    @(negedge clk); #1 trip = '1;
    idle(5);
    rd(5, d); check("R7 all-trip line 21", {16'h0, d}, 32'h0800);
    @(negedge clk); #1 lb1 = 1'b1;
    idle(5);
    rd(5, d); check("R7 line 22 needs both", {16'h0, d}, 32'h0);
    @(negedge clk); #1 lb2 = 1'b1;
    idle(5);
    rd(5, d); check("R7 line 22 both high", {16'h0, d}, 32'h2000);
    @(negedge clk); #1 hb = 1'b1;
    idle(5);
    rd(5, d); check("R7 heartbeat line 23", {16'h0, d}, 32'h8000);

    // R8 enable gating
    wr(6, 16'h0000);
    @(negedge clk); #1 hb = 1'b0;
    idle(5);
    check("R8 request low while disabled", {31'h0, irq_req}, 32'h0);
    wr(6, 16'h0AA5);
    check("R8 request on re-enable", {31'h0, irq_req}, 32'h1);
    rd(5, d); check("R8 edge captured while disabled", {16'h0, d}, 32'h4000);

    // R10 re-arm
    for (int w = 0; w < 3; w++) wr(w, 16'h0000);
    @(negedge clk); #1 sig[4] = 1'b0;
    idle(5);
    check("R10 no request with masks off", {31'h0, irq_req}, 32'h0);
    for (int w = 0; w < 3; w++) wr(w, 16'hFFFF);
    @(negedge clk); #1 sig[4] = 1'b1;
    idle(5);
    check("R10 request after re-arm", {31'h0, irq_req}, 32'h1);
    rd(3, d); check("R10 re-armed edge bit", {16'h0, d}, 32'h0200);

    idle(3);
    finish_up();
  end
endmodule